// File: doc/BRIEF.md
# Power-Down Clock Output Sequencer

This block decides when each clock output of a clock synthesizer may run and how it is parked during power-down. A single shared pin first serves as an active-low power-good input. Once that pin has been seen low, it becomes an asynchronous, active-high power-down request. The pin passes through a two-flop synchronizer. A request is accepted only after two consecutive rising edges of the CPU clock have seen it high.

After a request is accepted, every output parks on its own falling edge, so no output produces a runt pulse. Single-ended outputs are held low. Each differential pair parks when its complement falls, and a per-pair drive-mode bit selects one of two parked encodings. A reference-cycle timeout parks a pair whose complement never toggles.

When the request is released, the sequencer waits for the PLL lock input. It then enables every output on the same reference cycle. A new request that arrives while the sequencer is waiting for lock returns it to the parked state.

All logic runs on the reference clock `clk`. The CPU clock and the output clocks are derived from `clk` and are sampled directly. Only the pin is treated as asynchronous.

Top module: `pd_clock_sequencer`

## Requirements
- R1: Until the synchronized pin has been seen low once, the pin is not treated as a request, and every output stays parked whatever `pll_lock` does.
- R2: A power-down request is accepted only after the synchronized pin is high at two consecutive rising edges of `cpu_clk`. A high pulse that covers at most one such edge has no effect on any output.
- R3: After acceptance, `se_run[i]` falls in the same reference cycle in which `se_clk[i]` is first sampled low after being sampled high. This happens no later than 16 cycles plus one period of that clock after the pin rises.
- R4: After acceptance, `diff_run[i]` falls in the reference cycle in which `diff_clk_c[i]` is first sampled low after being sampled high. This happens within 4 periods of that complement clock.
- R5: If the complement of pair i never toggles, `diff_run[i]` falls between DIFF_TIMEOUT and DIFF_TIMEOUT+16 reference cycles after the pin rises.
- R6: Per pair i, while the pair runs, `diff_t_oe[i]` and `diff_c_oe[i]` are both 1. While it is parked, `diff_c_oe[i]` is 0 and `diff_t_oe[i]` is the inverse of `diff_mode[i]`. So mode 0 holds the true output high, and mode 1 tri-states both outputs.
- R7: Outputs are enabled only while `pll_lock` is high and no request is pending. All `se_run` and `diff_run` bits rise on the same reference cycle.
- R8: A request accepted while the sequencer is waiting for lock keeps every output parked, even if lock then arrives while the pin is still high. Enabling resumes only after the pin is low again.
- R9: After reset, every run bit is 0 and the differential enables show the parked encoding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_pin | input | 1 | Shared power-good / power-down pin, asynchronous |
| cpu_clk | input | 1 | CPU clock, sampled on `clk` |
| se_clk | input | N_SE | Single-ended output clocks, sampled |
| diff_clk_c | input | N_DIFF | Complement phase of each differential pair, sampled |
| diff_mode | input | N_DIFF | Parked drive mode per pair |
| pll_lock | input | 1 | PLL lock indication |
| se_run | output | N_SE | 1 lets the single-ended clock through, 0 holds it low |
| diff_run | output | N_DIFF | 1 lets the pair toggle, 0 parks it |
| diff_t_oe | output | N_DIFF | Output enable of the true leg (0 means tri-state) |
| diff_c_oe | output | N_DIFF | Output enable of the complement leg (0 means tri-state) |

## Verification
Parking is timed from the negative edge on which the bench raises the pin. Two synchronizer cycles, up to two CPU periods for qualification, one state cycle and the lane's own falling edge give each output a window. The bench records the sample in which each run bit fell and checks it against that window.

The edge rule is checked on the cycle the run bit falls. At that sample the lane's clock must read low, and it must have read high one sample earlier.

Enabling is checked on the first sample in which any run bit is high. At that sample all run bits must be high and lock must be high.

Ignored stimuli are checked after quiet periods long enough to cover the whole pipeline. These are glitches on the pin, the pin during the power-good phase, and lock arriving during a pending request. In each case the bench confirms that the outputs did not change.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;
  typedef enum logic [2:0] {
    ST_PWRGD  = 3'd0,
    ST_LOCK   = 3'd1,
    ST_RUN    = 3'd2,
    ST_STOP   = 3'd3,
    ST_PARKED = 3'd4
  } seq_state_t;

  localparam int QUAL_EDGES = 2;
endpackage

// File: rtl/pdseq_pin_qual.sv
module pdseq_pin_qual #(
  parameter int QUAL_EDGES = pdseq_pkg::QUAL_EDGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  input  logic cpu_clk,
  output logic pd_phase_o,
  output logic req_o,
  output logic rel_o
);
  localparam int CW = $clog2(QUAL_EDGES + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(QUAL_EDGES);

  logic          meta_q, sync_q;
  logic          cpu_q;
  logic          phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cpu_rise;

  assign cpu_rise = cpu_clk & ~cpu_q;

  always_comb begin
    phase_d = phase_q | ~sync_q;
    cnt_d   = cnt_q;
    if (!phase_q) begin
      cnt_d = '0;
    end else if (cpu_rise) begin
      if (!sync_q)               cnt_d = '0;
      else if (cnt_q != CNT_FULL) cnt_d = cnt_q + 1'b1;
    end
  end

  // Sync flops reset high: the pin's idle level before power-good is high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q  <= 1'b1;
      sync_q  <= 1'b1;
      cpu_q   <= 1'b0;
      phase_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      meta_q  <= pin_async;
      sync_q  <= meta_q;
      cpu_q   <= cpu_clk;
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pd_phase_o = phase_q;
  assign req_o      = phase_q & sync_q & (cnt_q == CNT_FULL);
  assign rel_o      = phase_q & ~sync_q;
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pd_phase,
  input  logic req,
  input  logic rel,
  input  logic pll_lock,
  input  logic all_parked,
  output logic start_o,
  output logic stop_o
);
  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    start_o = 1'b0;
    unique case (state_q)
      ST_PWRGD:  if (pd_phase) state_d = ST_LOCK;
      ST_LOCK: begin
        if (req) begin
          state_d = ST_PARKED;
        end else if (pll_lock) begin
          state_d = ST_RUN;
          start_o = 1'b1;
        end
      end
      ST_RUN:    if (req) state_d = ST_STOP;
      ST_STOP:   if (all_parked) state_d = ST_PARKED;
      ST_PARKED: if (rel) state_d = ST_LOCK;
      default:   state_d = ST_PWRGD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_PWRGD;
    else        state_q <= state_d;
  end

  assign stop_o = (state_q == ST_STOP);
endmodule

// File: rtl/pdseq_se_lane.sv
module pdseq_se_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_smp,
  input  logic start,
  input  logic stop,
  output logic run_o
);
  logic prev_q, run_q, run_d, fall;

  assign fall = prev_q & ~clk_smp;

  always_comb begin
    run_d = run_q;
    if (start)             run_d = 1'b1;
    else if (stop && fall) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      prev_q <= clk_smp;
      run_q  <= run_d;
    end
  end

  assign run_o = run_q;
endmodule

// File: rtl/pdseq_diff_lane.sv
module pdseq_diff_lane #(
  parameter int TIMEOUT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clkc_smp,
  input  logic mode,
  input  logic start,
  input  logic stop,
  output logic run_o,
  output logic t_oe_o,
  output logic c_oe_o
);
  localparam int TW = $clog2(TIMEOUT + 1);
  localparam logic [TW-1:0] CNT_LAST = TW'(TIMEOUT - 1);

  logic          prev_q, run_q, run_d, fall, expire;
  logic [TW-1:0] cnt_q, cnt_d;

  assign fall   = prev_q & ~clkc_smp;
  assign expire = stop & run_q & (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = (stop && run_q) ? cnt_q + 1'b1 : '0;
    run_d = run_q;
    if (start)                      run_d = 1'b1;
    else if (stop && (fall || expire)) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= clkc_smp;
      run_q  <= run_d;
      cnt_q  <= cnt_d;
    end
  end

  assign run_o  = run_q;
  assign t_oe_o = run_q | ~mode;
  assign c_oe_o = run_q;
endmodule

// File: rtl/pd_clock_sequencer.sv
module pd_clock_sequencer #(
  parameter int N_SE         = 2,
  parameter int N_DIFF       = 2,
  parameter int DIFF_TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd_pin,
  input  logic              cpu_clk,
  input  logic [N_SE-1:0]   se_clk,
  input  logic [N_DIFF-1:0] diff_clk_c,
  input  logic [N_DIFF-1:0] diff_mode,
  input  logic              pll_lock,
  output logic [N_SE-1:0]   se_run,
  output logic [N_DIFF-1:0] diff_run,
  output logic [N_DIFF-1:0] diff_t_oe,
  output logic [N_DIFF-1:0] diff_c_oe
);
  logic rst_meta_q, rst_sync_q;
  logic pd_phase, req, rel, start, stop, all_parked;

  // Reset asserts asynchronously, releases on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  pdseq_pin_qual u_qual (
    .clk(clk), .rst_n(rst_sync_q), .pin_async(pd_pin), .cpu_clk(cpu_clk),
    .pd_phase_o(pd_phase), .req_o(req), .rel_o(rel)
  );

  assign all_parked = ~(|se_run) & ~(|diff_run);

  pdseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_sync_q), .pd_phase(pd_phase), .req(req), .rel(rel),
    .pll_lock(pll_lock), .all_parked(all_parked), .start_o(start), .stop_o(stop)
  );

  for (genvar i = 0; i < N_SE; i++) begin : g_se
    pdseq_se_lane u_lane (
      .clk(clk), .rst_n(rst_sync_q), .clk_smp(se_clk[i]),
      .start(start), .stop(stop), .run_o(se_run[i])
    );
  end

  for (genvar j = 0; j < N_DIFF; j++) begin : g_diff
    pdseq_diff_lane #(.TIMEOUT(DIFF_TIMEOUT)) u_lane (
      .clk(clk), .rst_n(rst_sync_q), .clkc_smp(diff_clk_c[j]), .mode(diff_mode[j]),
      .start(start), .stop(stop), .run_o(diff_run[j]),
      .t_oe_o(diff_t_oe[j]), .c_oe_o(diff_c_oe[j])
    );
  end
endmodule

// File: rtl/pdseq_checker.sv
module pdseq_checker #(
  parameter int N_SE   = 2,
  parameter int N_DIFF = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pd_pin,
  input logic              pll_lock,
  input logic [N_SE-1:0]   se_clk,
  input logic [N_DIFF-1:0] diff_clk_c,
  input logic [N_DIFF-1:0] diff_mode,
  input logic [N_SE-1:0]   se_run,
  input logic [N_DIFF-1:0] diff_run,
  input logic [N_DIFF-1:0] diff_t_oe,
  input logic [N_DIFF-1:0] diff_c_oe
);
  logic ever_low_q;
  logic [N_SE+N_DIFF-1:0] runs;

  assign runs = {se_run, diff_run};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ever_low_q <= 1'b0;
    else if (!pd_pin) ever_low_q <= 1'b1;
  end

  a_r1_parked_before_pwrgd: assert property (@(posedge clk) disable iff (!rst_n)
    !ever_low_q |-> (runs == '0));

  a_r7_enable_together: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|runs) |-> (&runs));

  a_r7_enable_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|runs) |-> $past(pll_lock));

  for (genvar i = 0; i < N_SE; i++) begin : g_se_chk
    a_r3_se_park_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(se_run[i]) |-> (!$past(se_clk[i]) && $past(se_clk[i], 2)));
  end

  for (genvar j = 0; j < N_DIFF; j++) begin : g_diff_chk
    a_r6_running_drives_both: assert property (@(posedge clk) disable iff (!rst_n)
      diff_run[j] |-> (diff_t_oe[j] && diff_c_oe[j]));
    a_r6_parked_encoding: assert property (@(posedge clk) disable iff (!rst_n)
      !diff_run[j] |-> (!diff_c_oe[j] && (diff_t_oe[j] == !diff_mode[j])));
  end
endmodule

bind pd_clock_sequencer pdseq_checker #(.N_SE(N_SE), .N_DIFF(N_DIFF)) u_pdseq_chk (
  .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .pll_lock(pll_lock),
  .se_clk(se_clk), .diff_clk_c(diff_clk_c), .diff_mode(diff_mode),
  .se_run(se_run), .diff_run(diff_run), .diff_t_oe(diff_t_oe), .diff_c_oe(diff_c_oe)
);

// File: tb/pd_clock_sequencer_test.sv
`timescale 1ns/1ps
module pd_clock_sequencer_test;
  localparam int N_SE = 2, N_DIFF = 2, TOUT = 64;
  localparam int SE_P0 = 6, SE_P1 = 8, DF_P0 = 6, DF_P1 = 10, CPU_P = 4;

  logic clk = 1'b0;
  logic rst_n, pd_pin, pll_lock, freeze;
  logic [N_DIFF-1:0] diff_mode;
  int cyc = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic cpu_clk;
  logic [N_SE-1:0] se_clk;
  logic [N_DIFF-1:0] diff_clk_c;
  logic [N_SE-1:0] se_run;
  logic [N_DIFF-1:0] diff_run, diff_t_oe, diff_c_oe;

  always #2.5 clk = ~clk;
  always @(negedge clk) cyc <= cyc + 1;

  assign cpu_clk       = (cyc % CPU_P) < CPU_P/2;
  assign se_clk[0]     = (cyc % SE_P0) < SE_P0/2;
  assign se_clk[1]     = (cyc % SE_P1) < SE_P1/2;
  assign diff_clk_c[0] = (cyc % DF_P0) >= DF_P0/2;
  assign diff_clk_c[1] = freeze ? 1'b1 : (((cyc + 1) % DF_P1) < DF_P1/2);

  pd_clock_sequencer #(.N_SE(N_SE), .N_DIFF(N_DIFF), .DIFF_TIMEOUT(TOUT)) uut (
    .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .cpu_clk(cpu_clk), .se_clk(se_clk),
    .diff_clk_c(diff_clk_c), .diff_mode(diff_mode), .pll_lock(pll_lock),
    .se_run(se_run), .diff_run(diff_run), .diff_t_oe(diff_t_oe), .diff_c_oe(diff_c_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  // Per-cycle monitor, sampled 1 ns after the active edge.
  logic [N_SE-1:0] p_se_run, p_se_clk;
  logic [N_DIFF-1:0] p_df_run, p_df_clk;
  logic p_rst = 1'b0;
  int fall_se [N_SE];
  int fall_df [N_DIFF];

  always @(posedge clk) begin
    #1;
    if (rst_n && p_rst) begin
      if ({p_se_run, p_df_run} == '0 && {se_run, diff_run} != '0) begin
        check(&{se_run, diff_run}, "R7 all enabled together", {se_run, diff_run}, 4'hF);
        check(pll_lock, "R7 enable needs lock", pll_lock, 1);
      end
      for (int i = 0; i < N_SE; i++)
        if (p_se_run[i] && !se_run[i]) begin
          check(!se_clk[i] && p_se_clk[i], "R3 single-ended park on falling edge",
                {p_se_clk[i], se_clk[i]}, 2'b10);
          fall_se[i] = cyc;
        end
      for (int j = 0; j < N_DIFF; j++)
        if (p_df_run[j] && !diff_run[j]) begin
          if (!(freeze && j == N_DIFF-1))
            check(!diff_clk_c[j] && p_df_clk[j], "R4 pair park on complement fall",
                  {p_df_clk[j], diff_clk_c[j]}, 2'b10);
          fall_df[j] = cyc;
        end
      check(diff_t_oe == (diff_run | ~diff_mode), "R6 true-leg enable", diff_t_oe,
            diff_run | ~diff_mode);
      check(diff_c_oe == diff_run, "R6 complement-leg enable", diff_c_oe, diff_run);
    end
    p_se_run = se_run; p_df_run = diff_run;
    p_se_clk = se_clk; p_df_clk = diff_clk_c;
    p_rst = rst_n;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input bit want_run, input string req);
    logic [N_SE+N_DIFF-1:0] exp;
    exp = want_run ? '1 : '0;
    check({se_run, diff_run} == exp, req, {se_run, diff_run}, exp);
  endtask

  task automatic clear_falls();
    for (int i = 0; i < N_SE; i++) fall_se[i] = -1;
    for (int j = 0; j < N_DIFF; j++) fall_df[j] = -1;
  endtask

  task automatic run_case(input logic [N_DIFF-1:0] mode, input int ofs);
    int t0;
    int sp [N_SE];
    int dp [N_DIFF];
    sp[0] = SE_P0; sp[1] = SE_P1; dp[0] = DF_P0; dp[1] = DF_P1;
    @(negedge clk);
    rst_n = 1'b0; pd_pin = 1'b1; pll_lock = 1'b1; freeze = 1'b0; diff_mode = mode;
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(6);
    check_all(0, "R9 reset parks every output");
    check(diff_t_oe == ~mode && diff_c_oe == '0, "R9 reset encoding",
          {diff_t_oe, diff_c_oe}, {~mode, 2'b00});
    wait_cyc(20 + ofs);
    check_all(0, "R1 power-good phase ignores lock and pin");
    pd_pin = 1'b0;
    wait_cyc(12);
    check_all(1, "R7 outputs enabled after power-good and lock");
    // Short glitch: covers at most one CPU rising edge.
    wait_cyc(ofs);
    pd_pin = 1'b1;
    wait_cyc(3);
    pd_pin = 1'b0;
    wait_cyc(30);
    check_all(1, "R2 single-edge glitch ignored");
    // Real request.
    clear_falls();
    wait_cyc(ofs);
    pd_pin = 1'b1; t0 = cyc;
    wait_cyc(40 + 4 * DF_P1);
    for (int i = 0; i < N_SE; i++)
      check(fall_se[i] >= t0 + 4 && fall_se[i] <= t0 + 16 + sp[i],
            "R3 single-ended park window", fall_se[i] - t0, 16 + sp[i]);
    for (int j = 0; j < N_DIFF; j++)
      check(fall_df[j] >= t0 + 4 && fall_df[j] <= t0 + 13 + 4 * dp[j],
            "R4 pair park window", fall_df[j] - t0, 13 + 4 * dp[j]);
    check_all(0, "R2 qualified request parks all");
    // Release without lock, then a request while waiting for lock.
    pll_lock = 1'b0; pd_pin = 1'b0;
    wait_cyc(30);
    check_all(0, "R7 no enable without lock");
    pd_pin = 1'b1;
    wait_cyc(12);
    pll_lock = 1'b1;
    wait_cyc(20);
    check_all(0, "R8 request during lock wait keeps parked");
    pd_pin = 1'b0;
    wait_cyc(12);
    check_all(1, "R8 enable resumes after release");
    // Stuck complement on the last pair.
    wait_cyc(ofs);
    freeze = 1'b1;
    wait_cyc(2);
    clear_falls();
    pd_pin = 1'b1; t0 = cyc;
    wait_cyc(TOUT + 40);
    check(fall_df[N_DIFF-1] >= t0 + TOUT && fall_df[N_DIFF-1] <= t0 + TOUT + 16,
          "R5 timeout park window", fall_df[N_DIFF-1] - t0, TOUT);
    check(fall_df[0] >= t0 + 4 && fall_df[0] <= t0 + 13 + 4 * DF_P0,
          "R4 pair park with neighbour stuck", fall_df[0] - t0, 13 + 4 * DF_P0);
    check_all(0, "R5 all parked after timeout");
  endtask

  initial begin
    rst_n = 1'b0; pd_pin = 1'b1; pll_lock = 1'b0; freeze = 1'b0; diff_mode = '0;
    clear_falls();
    for (int m = 0; m < (1 << N_DIFF); m++)
      for (int o = 0; o < 4; o++)
        run_case(N_DIFF'(m), o);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule